// File: doc/BRIEF.md
# Accumulator Machine Control Sequencer

This block is the control unit of a small accumulator machine. It is a Moore state machine that walks the datapath through instruction fetch, opcode decode and execute. Every state drives a fixed pattern of control lines: the mux selects that feed the program counter, the memory address register and the accumulator; the load enables of the five datapath registers; the ALU operation code; and the memory write strobe. The datapath sends back only two things, the opcode field of the instruction register and the accumulator zero flag.

Most states move on unconditionally at every clock. Decode is the only state with many exits. The conditional jump test is the only state whose exit depends on the zero flag. Multiply and divide take their operands in the same way as the other arithmetic operations. Each then stays in its execute state for a fixed, parameterised number of cycles, one for each step of an iterative unit, before the accumulator is loaded. The arithmetic units are not part of this block.

Top module: `accum_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, every control output is low from that edge on. In the first cycle after `rst` falls, the machine is in the first fetch state.
- R2: Fetch takes three states in this order. The first has `ld_mar`=1 and `sel_mar`=0 (address from PC). The second has `ld_mdr`=1, `ld_pc`=1 and `sel_pc`=0 (PC increment). The third has `ld_ir`=1. A decode state with every output low follows.
- R3: Decode branches on the opcode: 0x01 add, 0x02 subtract, 0x03 multiply, 0x04 divide, 0x05 XOR, 0x06 jump, 0x07 jump-if-zero, 0x08 store, 0x09 load.
- R4: Add, subtract, multiply, divide, XOR and load spend one state with `ld_mar`=1 and `sel_mar`=1 (address from the IR address field), then one state with only `ld_mdr`=1.
- R5: Add, subtract and XOR then spend one execute state with `ld_acc`=1, `sel_acc`=1 (ALU result) and `alu_op` equal to 1, 2 and 0 respectively. Load spends one state with `ld_acc`=1 and `sel_acc`=0 (memory data). Each then returns to the first fetch state.
- R6: Multiply holds `alu_op`=3 for MUL_STEPS cycles and divide holds `alu_op`=4 for DIV_STEPS cycles. `ld_acc`=1 with `sel_acc`=1 is raised only in the last of these cycles. The machine then returns to fetch.
- R7: Jump spends one state with `ld_pc`=1 and `sel_pc`=1 (branch target), then returns to fetch.
- R8: Jump-if-zero spends one test state with every output low. If `zero_flag` is high there, the jump state of R7 follows. If it is low, fetch follows.
- R9: Store spends one state with `ld_mar`=1 and `sel_mar`=1, then exactly one cycle with `mem_we`=1 and no load enables, then returns to fetch.
- R10: Any opcode outside 0x01 to 0x09 sends decode straight back to the first fetch state.
- R11: `zero_flag` has no effect in any state other than the jump-if-zero test. An add with the flag high shows the same pattern as one with it low.
- R12: A reset raised in the middle of a multi-cycle execute restarts the step count, so the next multiply again takes MUL_STEPS cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OPC_W | Opcode field of the instruction register |
| zero_flag | input | 1 | Accumulator equals zero |
| sel_pc | output | 1 | PC mux: 0 increment, 1 branch target |
| sel_mar | output | 1 | MAR mux: 0 PC, 1 IR address field |
| sel_acc | output | 1 | ACC mux: 0 memory data register, 1 ALU result |
| ld_mar | output | 1 | Load enable, memory address register |
| ld_pc | output | 1 | Load enable, program counter |
| ld_acc | output | 1 | Load enable, accumulator |
| ld_mdr | output | 1 | Load enable, memory data register |
| ld_ir | output | 1 | Load enable, instruction register |
| alu_op | output | 3 | ALU operation: 0 XOR, 1 add, 2 subtract, 3 multiply, 4 divide |
| mem_we | output | 1 | Memory write strobe |

## Verification
The outputs are a pure function of the current state, so a wrong state shows at the ports in the same cycle it is entered. A wrong decode branch appears one cycle after decode as a missing operand-address pattern, or as a fetch pattern that comes too early. An off-by-one in the multiply or divide step count moves the single accumulator load one cycle early or late, or returns to fetch at the wrong time. The bench therefore compares the whole control vector at every cycle of each instruction.

// File: rtl/acq_pkg.sv
package acq_pkg;

   localparam int unsigned ALU_W = 3;

   localparam logic [ALU_W-1:0] ALU_XOR = 3'd0;
   localparam logic [ALU_W-1:0] ALU_ADD = 3'd1;
   localparam logic [ALU_W-1:0] ALU_SUB = 3'd2;
   localparam logic [ALU_W-1:0] ALU_MUL = 3'd3;
   localparam logic [ALU_W-1:0] ALU_DIV = 3'd4;

   localparam int unsigned OPV_ADD   = 1;
   localparam int unsigned OPV_SUB   = 2;
   localparam int unsigned OPV_MUL   = 3;
   localparam int unsigned OPV_DIV   = 4;
   localparam int unsigned OPV_XOR   = 5;
   localparam int unsigned OPV_JMP   = 6;
   localparam int unsigned OPV_JZ    = 7;
   localparam int unsigned OPV_STORE = 8;
   localparam int unsigned OPV_LOAD  = 9;

   typedef enum logic [4:0] {
      S_F1, S_F2, S_F3, S_DEC,
      S_ADD_A, S_ADD_R, S_ADD_X,
      S_SUB_A, S_SUB_R, S_SUB_X,
      S_MUL_A, S_MUL_R, S_MUL_X,
      S_DIV_A, S_DIV_R, S_DIV_X,
      S_XOR_A, S_XOR_R, S_XOR_X,
      S_LD_A,  S_LD_R,  S_LD_X,
      S_JMP_X, S_JZ_T,
      S_ST_A,  S_ST_W
   } seq_state_e;

   typedef struct packed {
      logic             sel_pc;
      logic             sel_mar;
      logic             sel_acc;
      logic             ld_mar;
      logic             ld_pc;
      logic             ld_acc;
      logic             ld_mdr;
      logic             ld_ir;
      logic [ALU_W-1:0] alu;
      logic             we;
   } ctl_t;

   localparam ctl_t CTL_IDLE = '0;

endpackage

// File: rtl/acq_step_ctr.sv
module acq_step_ctr
   import acq_pkg::*;
#(
   parameter int unsigned MUL_STEPS = 4,
   parameter int unsigned DIV_STEPS = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   input  logic is_div,
   output logic last
);
   localparam int unsigned MAX_STEPS = (MUL_STEPS > DIV_STEPS) ? MUL_STEPS : DIV_STEPS;
   localparam int unsigned CNT_W     = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1;
   localparam logic [CNT_W-1:0] MUL_END = CNT_W'(MUL_STEPS - 1);
   localparam logic [CNT_W-1:0] DIV_END = CNT_W'(DIV_STEPS - 1);

   generate
      if (MAX_STEPS == 1) begin : g_single
         assign last = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         logic [CNT_W-1:0] end_val;

         assign end_val = is_div ? DIV_END : MUL_END;
         assign last    = (cnt_q == end_val);

         always_ff @(posedge clk) begin
            if (rst) begin
               cnt_q <= '0;
            end else if (run && !last) begin
               cnt_q <= cnt_q + 1'b1;
            end else begin
               cnt_q <= '0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/acq_next_state.sv
module acq_next_state
   import acq_pkg::*;
#(
   parameter int unsigned OPC_W = 8
) (
   input  seq_state_e       cur,
   input  logic [OPC_W-1:0] opcode,
   input  logic             zero_flag,
   input  logic             run_last,
   output seq_state_e       nxt
);
   function automatic seq_state_e dispatch(input logic [OPC_W-1:0] op);
      seq_state_e d;
      if      (op == OPC_W'(OPV_ADD))   d = S_ADD_A;
      else if (op == OPC_W'(OPV_SUB))   d = S_SUB_A;
      else if (op == OPC_W'(OPV_MUL))   d = S_MUL_A;
      else if (op == OPC_W'(OPV_DIV))   d = S_DIV_A;
      else if (op == OPC_W'(OPV_XOR))   d = S_XOR_A;
      else if (op == OPC_W'(OPV_JMP))   d = S_JMP_X;
      else if (op == OPC_W'(OPV_JZ))    d = S_JZ_T;
      else if (op == OPC_W'(OPV_STORE)) d = S_ST_A;
      else if (op == OPC_W'(OPV_LOAD))  d = S_LD_A;
      else                              d = S_F1;
      return d;
   endfunction

   always_comb begin
      unique case (cur)
         S_F1:    nxt = S_F2;
         S_F2:    nxt = S_F3;
         S_F3:    nxt = S_DEC;
         S_DEC:   nxt = dispatch(opcode);
         S_ADD_A: nxt = S_ADD_R;
         S_ADD_R: nxt = S_ADD_X;
         S_SUB_A: nxt = S_SUB_R;
         S_SUB_R: nxt = S_SUB_X;
         S_MUL_A: nxt = S_MUL_R;
         S_MUL_R: nxt = S_MUL_X;
         S_MUL_X: nxt = run_last ? S_F1 : S_MUL_X;
         S_DIV_A: nxt = S_DIV_R;
         S_DIV_R: nxt = S_DIV_X;
         S_DIV_X: nxt = run_last ? S_F1 : S_DIV_X;
         S_XOR_A: nxt = S_XOR_R;
         S_XOR_R: nxt = S_XOR_X;
         S_LD_A:  nxt = S_LD_R;
         S_LD_R:  nxt = S_LD_X;
         S_JZ_T:  nxt = zero_flag ? S_JMP_X : S_F1;
         S_ST_A:  nxt = S_ST_W;
         default: nxt = S_F1;
      endcase
   end

endmodule

// File: rtl/acq_out_decode.sv
module acq_out_decode
   import acq_pkg::*;
(
   input  seq_state_e cur,
   input  logic       run_last,
   output ctl_t       ctl
);
   always_comb begin
      ctl = CTL_IDLE;
      unique case (cur)
         S_F1: ctl.ld_mar = 1'b1;
         S_F2: begin
            ctl.ld_mdr = 1'b1;
            ctl.ld_pc  = 1'b1;
         end
         S_F3: ctl.ld_ir = 1'b1;
         S_ADD_A, S_SUB_A, S_MUL_A, S_DIV_A, S_XOR_A, S_LD_A, S_ST_A: begin
            ctl.ld_mar  = 1'b1;
            ctl.sel_mar = 1'b1;
         end
         S_ADD_R, S_SUB_R, S_MUL_R, S_DIV_R, S_XOR_R, S_LD_R:
            ctl.ld_mdr = 1'b1;
         S_ADD_X: begin
            ctl.ld_acc  = 1'b1;
            ctl.sel_acc = 1'b1;
            ctl.alu     = ALU_ADD;
         end
         S_SUB_X: begin
            ctl.ld_acc  = 1'b1;
            ctl.sel_acc = 1'b1;
            ctl.alu     = ALU_SUB;
         end
         S_XOR_X: begin
            ctl.ld_acc  = 1'b1;
            ctl.sel_acc = 1'b1;
            ctl.alu     = ALU_XOR;
         end
         S_MUL_X: begin
            ctl.alu     = ALU_MUL;
            ctl.ld_acc  = run_last;
            ctl.sel_acc = run_last;
         end
         S_DIV_X: begin
            ctl.alu     = ALU_DIV;
            ctl.ld_acc  = run_last;
            ctl.sel_acc = run_last;
         end
         S_LD_X: ctl.ld_acc = 1'b1;
         S_JMP_X: begin
            ctl.ld_pc  = 1'b1;
            ctl.sel_pc = 1'b1;
         end
         S_ST_W: ctl.we = 1'b1;
         default: ctl = CTL_IDLE;
      endcase
   end

endmodule

// File: rtl/accum_sequencer.sv
module accum_sequencer
   import acq_pkg::*;
#(
   parameter int unsigned OPC_W     = 8,
   parameter int unsigned MUL_STEPS = 4,
   parameter int unsigned DIV_STEPS = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OPC_W-1:0] opcode,
   input  logic             zero_flag,
   output logic             sel_pc,
   output logic             sel_mar,
   output logic             sel_acc,
   output logic             ld_mar,
   output logic             ld_pc,
   output logic             ld_acc,
   output logic             ld_mdr,
   output logic             ld_ir,
   output logic [2:0]       alu_op,
   output logic             mem_we
);
   initial begin
      if (OPC_W < 4)      $fatal(1, "OPC_W must hold opcode 9");
      if (MUL_STEPS < 1)  $fatal(1, "MUL_STEPS must be at least 1");
      if (DIV_STEPS < 1)  $fatal(1, "DIV_STEPS must be at least 1");
   end

   seq_state_e state_q;
   seq_state_e state_d;
   logic       run;
   logic       run_last;
   ctl_t       ctl;
   ctl_t       ctl_out;

   assign run = (state_q == S_MUL_X) || (state_q == S_DIV_X);

   acq_step_ctr #(
      .MUL_STEPS (MUL_STEPS),
      .DIV_STEPS (DIV_STEPS)
   ) u_steps (
      .clk    (clk),
      .rst    (rst),
      .run    (run),
      .is_div (state_q == S_DIV_X),
      .last   (run_last)
   );

   acq_next_state #(
      .OPC_W (OPC_W)
   ) u_next (
      .cur       (state_q),
      .opcode    (opcode),
      .zero_flag (zero_flag),
      .run_last  (run_last),
      .nxt       (state_d)
   );

   acq_out_decode u_dec (
      .cur      (state_q),
      .run_last (run_last),
      .ctl      (ctl)
   );

   always_ff @(posedge clk) begin
      if (rst) state_q <= S_F1;
      else     state_q <= state_d;
   end

   assign ctl_out = rst ? CTL_IDLE : ctl;

   assign sel_pc  = ctl_out.sel_pc;
   assign sel_mar = ctl_out.sel_mar;
   assign sel_acc = ctl_out.sel_acc;
   assign ld_mar  = ctl_out.ld_mar;
   assign ld_pc   = ctl_out.ld_pc;
   assign ld_acc  = ctl_out.ld_acc;
   assign ld_mdr  = ctl_out.ld_mdr;
   assign ld_ir   = ctl_out.ld_ir;
   assign alu_op  = ctl_out.alu;
   assign mem_we  = ctl_out.we;

endmodule

// File: rtl/acq_chk.sv
module acq_chk (
   input logic       clk,
   input logic       rst,
   input logic       sel_pc,
   input logic       sel_mar,
   input logic       ld_mar,
   input logic       ld_pc,
   input logic       ld_acc,
   input logic       ld_mdr,
   input logic       ld_ir,
   input logic       mem_we
);
   logic fetch1;
   assign fetch1 = ld_mar && !sel_mar && !ld_pc && !ld_mdr;

   assert_reset_release_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> fetch1);

   assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
      fetch1 |=> ld_mdr && ld_pc && !sel_pc);

   assert_decode_quiet_R2: assert property (@(posedge clk) disable iff (rst)
      ld_ir |=> !(ld_mar || ld_pc || ld_acc || ld_mdr || ld_ir || mem_we));

   assert_operand_read_R4: assert property (@(posedge clk) disable iff (rst)
      (ld_mar && sel_mar) |=> ((ld_mdr && !ld_pc) || mem_we));

   assert_exec_return_R5: assert property (@(posedge clk) disable iff (rst)
      ld_acc |=> fetch1);

   assert_jump_return_R7: assert property (@(posedge clk) disable iff (rst)
      (ld_pc && sel_pc) |=> fetch1);

   assert_store_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> !mem_we && fetch1);

   assert_load_count_R2: assert property (@(posedge clk) disable iff (rst)
      $countones({ld_mar, ld_pc, ld_acc, ld_mdr, ld_ir}) <= 2);

endmodule

bind accum_sequencer acq_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .sel_pc  (sel_pc),
   .sel_mar (sel_mar),
   .ld_mar  (ld_mar),
   .ld_pc   (ld_pc),
   .ld_acc  (ld_acc),
   .ld_mdr  (ld_mdr),
   .ld_ir   (ld_ir),
   .mem_we  (mem_we)
);

// File: tb/accum_sequencer_tb.sv
module accum_sequencer_tb;
   localparam int MUL_N = 4;
   localparam int DIV_N = 4;

   logic       clk = 1'b0;
   logic       rst;
   logic [7:0] opcode;
   logic       zero_flag;
   logic       sel_pc, sel_mar, sel_acc, ld_mar, ld_pc, ld_acc, ld_mdr, ld_ir, mem_we;
   logic [2:0] alu_op;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   accum_sequencer #(.OPC_W(8), .MUL_STEPS(MUL_N), .DIV_STEPS(DIV_N)) u_dut (
      .clk(clk), .rst(rst), .opcode(opcode), .zero_flag(zero_flag),
      .sel_pc(sel_pc), .sel_mar(sel_mar), .sel_acc(sel_acc), .ld_mar(ld_mar),
      .ld_pc(ld_pc), .ld_acc(ld_acc), .ld_mdr(ld_mdr), .ld_ir(ld_ir),
      .alu_op(alu_op), .mem_we(mem_we)
   );

   // {sel_pc,sel_mar,sel_acc,ld_mar,ld_pc,ld_acc,ld_mdr,ld_ir,alu_op[2:0],mem_we}
   localparam logic [11:0] P_ZERO = 12'b000_00000_000_0;
   localparam logic [11:0] P_F1   = 12'b000_10000_000_0;
   localparam logic [11:0] P_F2   = 12'b000_01010_000_0;
   localparam logic [11:0] P_F3   = 12'b000_00001_000_0;
   localparam logic [11:0] P_OPA  = 12'b010_10000_000_0;
   localparam logic [11:0] P_OPR  = 12'b000_00010_000_0;
   localparam logic [11:0] P_ADD  = 12'b001_00100_001_0;
   localparam logic [11:0] P_SUB  = 12'b001_00100_010_0;
   localparam logic [11:0] P_XOR  = 12'b001_00100_000_0;
   localparam logic [11:0] P_LOAD = 12'b000_00100_000_0;
   localparam logic [11:0] P_MULW = 12'b000_00000_011_0;
   localparam logic [11:0] P_MULL = 12'b001_00100_011_0;
   localparam logic [11:0] P_DIVW = 12'b000_00000_100_0;
   localparam logic [11:0] P_DIVL = 12'b001_00100_100_0;
   localparam logic [11:0] P_JMP  = 12'b100_01000_000_0;
   localparam logic [11:0] P_STW  = 12'b000_00000_000_1;

   function automatic logic [11:0] obs();
      return {sel_pc, sel_mar, sel_acc, ld_mar, ld_pc, ld_acc, ld_mdr, ld_ir, alu_op, mem_we};
   endfunction

   task automatic expect_vec(input logic [11:0] exp, input string req, input string what);
      logic [11:0] act;
      act = obs();
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic nxt();
      @(negedge clk);
      #0.5;
   endtask

   // entry: first fetch state is visible now; exit: decode is visible
   task automatic do_fetch(input string req);
      expect_vec(P_F1, "R2", {req, " fetch1"});
      nxt(); expect_vec(P_F2, "R2", {req, " fetch2"});
      nxt(); expect_vec(P_F3, "R2", {req, " fetch3"});
      nxt(); expect_vec(P_ZERO, "R2", {req, " decode"});
   endtask

   task automatic do_operand(input string req);
      nxt(); expect_vec(P_OPA, "R4", {req, " operand address"});
      nxt(); expect_vec(P_OPR, "R4", {req, " operand read"});
   endtask

   task automatic back_to_fetch(input string req);
      nxt(); expect_vec(P_F1, req, "return to fetch");
   endtask

   task automatic t_single(input logic [7:0] op, input logic z, input logic [11:0] pat, input string req);
      opcode = op; zero_flag = z;
      do_fetch(req);
      do_operand(req);
      nxt(); expect_vec(pat, req, "execute");
      back_to_fetch(req);
   endtask

   task automatic t_multi(input logic [7:0] op, input int n, input logic [11:0] pw,
                          input logic [11:0] pl, input string req);
      opcode = op; zero_flag = 1'b0;
      do_fetch(req);
      do_operand(req);
      for (int k = 0; k < n; k++) begin
         nxt(); expect_vec((k == n - 1) ? pl : pw, req, "run step");
      end
      back_to_fetch(req);
   endtask

   task automatic t_jump();
      opcode = 8'h06; zero_flag = 1'b0;
      do_fetch("R7");
      nxt(); expect_vec(P_JMP, "R7", "jump load");
      back_to_fetch("R7");
   endtask

   task automatic t_jz(input logic z);
      opcode = 8'h07; zero_flag = z;
      do_fetch("R8");
      nxt(); expect_vec(P_ZERO, "R8", "jz test");
      if (z) begin
         nxt(); expect_vec(P_JMP, "R8", "jz taken");
      end
      back_to_fetch("R8");
   endtask

   task automatic t_store();
      opcode = 8'h08; zero_flag = 1'b0;
      do_fetch("R9");
      nxt(); expect_vec(P_OPA, "R9", "store address");
      nxt(); expect_vec(P_STW, "R9", "store write");
      back_to_fetch("R9");
   endtask

   task automatic t_illegal(input logic [7:0] op);
      opcode = op; zero_flag = 1'b1;
      do_fetch("R10");
      back_to_fetch("R10");
   endtask

   task automatic t_reset_mid();
      opcode = 8'h03; zero_flag = 1'b0;
      do_fetch("R12");
      do_operand("R12");
      nxt(); expect_vec(P_MULW, "R12", "run step 1");
      nxt(); expect_vec(P_MULW, "R12", "run step 2");
      @(negedge clk); rst = 1'b1; #0.5;
      expect_vec(P_ZERO, "R1", "reset asserted mid-run");
      nxt(); expect_vec(P_ZERO, "R1", "reset held");
      rst = 1'b0; #0.5;
      expect_vec(P_F1, "R1", "after reset release");
      t_multi(8'h03, MUL_N, P_MULW, P_MULL, "R12");
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; opcode = 8'h00; zero_flag = 1'b0;
      repeat (3) @(negedge clk);
      #0.5;
      expect_vec(P_ZERO, "R1", "outputs during reset");
      @(negedge clk);
      rst = 1'b0; #0.5;
      expect_vec(P_F1, "R1", "first cycle after reset");

      t_single(8'h01, 1'b0, P_ADD,  "R5");
      t_single(8'h01, 1'b1, P_ADD,  "R11");
      t_single(8'h02, 1'b0, P_SUB,  "R5");
      t_single(8'h05, 1'b0, P_XOR,  "R5");
      t_single(8'h09, 1'b1, P_LOAD, "R5");
      t_multi(8'h03, MUL_N, P_MULW, P_MULL, "R6");
      t_multi(8'h04, DIV_N, P_DIVW, P_DIVL, "R6");
      t_jump();
      t_jz(1'b1);
      t_jz(1'b0);
      t_store();
      t_illegal(8'h00);
      t_illegal(8'h0A);
      t_illegal(8'hFF);
      t_single(8'h01, 1'b0, P_ADD, "R3");
      t_reset_mid();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule